// File: doc/BRIEF.md
# D-Channel Stop/Go Access Arbiter

This block decides when a terminal on a shared passive bus may transmit on the ISDN D channel. The bus supplies a stop/go level: 1 means the D channel is free, 0 means another terminal holds it. The local layer-2 side raises a request. The arbiter grants it only on a D-bit boundary while the synchronised stop/go level is 1. If that level changes while the grant is held, the arbiter treats the change as a collision. It withdraws the grant at once and raises a single-cycle collision pulse.

The stop/go status leaves the block on a dedicated pin. It can also be copied into one bit of the command/indicate field of channel 2. While the grant is low, the D-channel bit stream toward the line interface is held at the idle value, all ones. A disable control lets the terminal assume sole use of the channel. In that case the status is forced to "go" and the local D bits pass straight through. A three-bit mode code picks the operating mode. Codes 0, 1 and 2 differ only in the data-clock rate. Code 4 is terminal mode, code 7 is single-channel mode, and codes 3, 5 and 6 are reserved.

Top module: `dch_access_arb`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, grant and collision are 0, the stop/go pin is 0 and the D line output is 1 (when the disable control is 0).
- R2: The stop/go pin shows the stop/go input after a two-flop synchroniser: the value sampled at clock edge k appears on the pin after edge k+1.
- R3: In modes 0, 1, 2, 4 and 7, the grant rises on the edge that sees a D-bit boundary strobe, a high request and a synchronised stop/go of 1, with no lockout pending; in no other case does a low grant rise.
- R4: A grant stays high while the request stays high and the synchronised stop/go does not change, and falls on the first edge that sees the request low.
- R5: A change of the synchronised stop/go seen while the grant is high clears the grant on that edge and raises collision for exactly one cycle; this takes priority over a request drop seen on the same edge.
- R6: After a collision the grant stays low while the request stays high; it can be granted again only after the request has been seen low and then high again with stop/go 1.
- R7: With the disable control 0, the D line output is 1 while the grant is low and equals the local D bit while the grant is high.
- R8: When mirroring is enabled and the mode is 0, 1, 2 or 4, bit 4 of the channel-2 command/indicate output carries the stop/go pin value; all other bits, and bit 4 otherwise, pass the command/indicate input unchanged.
- R9: In mode 7, bit 4 of the command/indicate output is never replaced, even with mirroring enabled.
- R10: With the disable control 1, the stop/go pin is 1, a mirrored command/indicate bit 4 is 1, the D line output equals the local D bit, the grant follows the request one edge later, and collision stays 0 whatever the stop/go input does.
- R11: In reserved modes 3, 5 and 6 with the disable control 0, the grant stays low, collision stays 0 and the D line output is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sg_in | input | 1 | Asynchronous stop/go level from the bus (1 = free) |
| dbit_tick | input | 1 | One-cycle strobe marking a D-bit boundary |
| req_i | input | 1 | D-channel access request from layer 2 |
| mode_i | input | 3 | Operating mode code |
| ci_mirror_en_i | input | 1 | Copy stop/go into the command/indicate field |
| access_dis_i | input | 1 | Disable arbitration; assume sole use of the channel |
| d_tx_i | input | 1 | Local D-channel bit |
| ci_ch2_i | input | 6 | Channel-2 command/indicate field from upstream |
| grant_o | output | 1 | D-channel access granted |
| collision_o | output | 1 | One-cycle collision pulse |
| sg_o | output | 1 | Stop/go status pin |
| ci_ch2_o | output | 6 | Channel-2 command/indicate field with mirrored status |
| d_line_o | output | 1 | D-channel bit toward the line interface |

## Verification
A collision and a request drop can land on the same clock edge. The bench provokes this by toggling stop/go while granted and lowering the request exactly two cycles later, when the toggle leaves the synchroniser. The reference model then expects the collision pulse, not a plain release. A grant attempt on a boundary strobe can also coincide with a fresh stop/go edge. Both cases are judged every clock against the bench's behavioural model, which keeps its own stop/go history queue.

// File: rtl/dch_arb_pkg.sv
package dch_arb_pkg;

    localparam logic [2:0] MODE_RATE_A  = 3'd0;
    localparam logic [2:0] MODE_RATE_B  = 3'd1;
    localparam logic [2:0] MODE_RATE_C  = 3'd2;
    localparam logic [2:0] MODE_TERM    = 3'd4;
    localparam logic [2:0] MODE_SINGLE  = 3'd7;

    typedef struct packed {
        logic grant;
        logic lock;
        logic coll;
    } arb_state_t;

    function automatic logic mode_arbitrates(input logic [2:0] m);
        return (m == MODE_RATE_A) || (m == MODE_RATE_B) || (m == MODE_RATE_C)
            || (m == MODE_TERM) || (m == MODE_SINGLE);
    endfunction

    function automatic logic mode_mirrors(input logic [2:0] m);
        return (m == MODE_RATE_A) || (m == MODE_RATE_B) || (m == MODE_RATE_C)
            || (m == MODE_TERM);
    endfunction

endpackage

// File: rtl/dch_sg_sync.sv
module dch_sg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o,
    output logic prev_o
);
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;
    logic              prev_q;
    logic              prev_d;

    always_comb begin
        chain_d[0] = async_i;
        prev_d     = chain_q[STAGES-1];
    end

    generate
        for (genvar i = 1; i < STAGES; i++) begin : g_stage
            always_comb chain_d[i] = chain_q[i-1];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
            prev_q  <= 1'b0;
        end else begin
            chain_q <= chain_d;
            prev_q  <= prev_d;
        end
    end

    assign sync_o = chain_q[STAGES-1];
    assign prev_o = prev_q;
endmodule

// File: rtl/dch_arb_core.sv
module dch_arb_core
    import dch_arb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sg_s,
    input  logic       sg_prev,
    input  logic       dbit_tick,
    input  logic       req_i,
    input  logic [2:0] mode_i,
    input  logic       access_dis_i,
    output logic       grant_o,
    output logic       coll_o
);
    arb_state_t st_q, st_d;
    logic       sg_edge;
    logic       arb_on;

    always_comb begin
        sg_edge = sg_s ^ sg_prev;
        arb_on  = !access_dis_i && mode_arbitrates(mode_i);
        st_d      = st_q;
        st_d.coll = 1'b0;
        if (access_dis_i) begin
            st_d.grant = req_i;
            st_d.lock  = 1'b0;
        end else if (!arb_on) begin
            st_d.grant = 1'b0;
            st_d.lock  = 1'b0;
        end else if (st_q.grant && sg_edge) begin
            st_d.grant = 1'b0;
            st_d.lock  = 1'b1;
            st_d.coll  = 1'b1;
        end else if (!req_i) begin
            st_d.grant = 1'b0;
            st_d.lock  = 1'b0;
        end else if (!st_q.grant && !st_q.lock && dbit_tick && sg_s) begin
            st_d.grant = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign grant_o = st_q.grant;
    assign coll_o  = st_q.coll;

    // R5: toggle while granted withdraws the grant and pulses collision
    a_r5_collision_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_on && st_q.grant && (sg_s != sg_prev)) |=> (!st_q.grant && st_q.coll));

    // R5: collision lasts exactly one cycle
    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.coll |=> !st_q.coll);

    // R3: a low grant only rises on a go boundary
    a_r3_grant_on_go: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_on && !st_q.grant && !(dbit_tick && sg_s)) |=> !st_q.grant);

    // R6: lockout holds the grant low while the request is held
    a_r6_lockout: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_on && st_q.lock && req_i) |=> !st_q.grant);

    // R11: reserved modes never grant or collide
    a_r11_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        (!access_dis_i && !mode_arbitrates(mode_i)) |=> (!st_q.grant && !st_q.coll));
endmodule

// File: rtl/dch_access_arb.sv
module dch_access_arb
    import dch_arb_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int CI_W        = 6,
    parameter int CI_SG_BIT   = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sg_in,
    input  logic            dbit_tick,
    input  logic            req_i,
    input  logic [2:0]      mode_i,
    input  logic            ci_mirror_en_i,
    input  logic            access_dis_i,
    input  logic            d_tx_i,
    input  logic [CI_W-1:0] ci_ch2_i,
    output logic            grant_o,
    output logic            collision_o,
    output logic            sg_o,
    output logic [CI_W-1:0] ci_ch2_o,
    output logic            d_line_o
);
    logic sg_s;
    logic sg_prev;
    logic mirror_on;

    dch_sg_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (sg_in),
        .sync_o  (sg_s),
        .prev_o  (sg_prev)
    );

    dch_arb_core i_core (
        .clk          (clk),
        .rst_n        (rst_n),
        .sg_s         (sg_s),
        .sg_prev      (sg_prev),
        .dbit_tick    (dbit_tick),
        .req_i        (req_i),
        .mode_i       (mode_i),
        .access_dis_i (access_dis_i),
        .grant_o      (grant_o),
        .coll_o       (collision_o)
    );

    always_comb begin
        sg_o      = access_dis_i | sg_s;
        mirror_on = ci_mirror_en_i && mode_mirrors(mode_i);
        ci_ch2_o  = ci_ch2_i;
        if (mirror_on) ci_ch2_o[CI_SG_BIT] = sg_o;
        if (access_dis_i || grant_o) d_line_o = d_tx_i;
        else                         d_line_o = 1'b1;
    end

    // R10: disabled arbitration is always go, transparent and collision-free
    a_r10_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        access_dis_i |-> (sg_o && (d_line_o == d_tx_i) && !collision_o));

    // R7: idle ones whenever access is not granted
    a_r7_idle_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (!access_dis_i && !grant_o) |-> d_line_o);

    // R9: single-channel mode never touches the command/indicate bit
    a_r9_no_mirror: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_SINGLE) |-> (ci_ch2_o[CI_SG_BIT] == ci_ch2_i[CI_SG_BIT]));
endmodule

// File: tb/test_dch_access_arb.sv
module test_dch_access_arb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sg_in = 1'b0;
    logic       dbit_tick = 1'b0;
    logic       req_i = 1'b0;
    logic [2:0] mode_i = 3'd4;
    logic       ci_mirror_en_i = 1'b1;
    logic       access_dis_i = 1'b0;
    logic       d_tx_i = 1'b0;
    logic [5:0] ci_ch2_i = 6'd0;
    logic       grant_o, collision_o, sg_o, d_line_o;
    logic [5:0] ci_ch2_o;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 0;
    string cur_tag = "R4";

    // behavioural reference
    bit m_grant, m_lock, m_coll;
    bit hist[$];

    dch_access_arb i_dch_access_arb (
        .clk(clk), .rst_n(rst_n), .sg_in(sg_in), .dbit_tick(dbit_tick),
        .req_i(req_i), .mode_i(mode_i), .ci_mirror_en_i(ci_mirror_en_i),
        .access_dis_i(access_dis_i), .d_tx_i(d_tx_i), .ci_ch2_i(ci_ch2_i),
        .grant_o(grant_o), .collision_o(collision_o), .sg_o(sg_o),
        .ci_ch2_o(ci_ch2_o), .d_line_o(d_line_o)
    );

    always #4 clk = ~clk;

    function automatic bit arb_mode(input logic [2:0] m);
        return m inside {3'd0, 3'd1, 3'd2, 3'd4, 3'd7};
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_grant = 0; m_lock = 0; m_coll = 0;
            hist = '{0, 0, 0};
        end else begin
            bit s_now, s_old, was_coll;
            s_now = hist[$-1];
            s_old = hist[$-2];
            was_coll = 0;
            if (access_dis_i) begin
                m_grant = req_i; m_lock = 0;
            end else if (!arb_mode(mode_i)) begin
                m_grant = 0; m_lock = 0;
            end else if (m_grant && (s_now != s_old)) begin
                m_grant = 0; m_lock = 1; was_coll = 1;
            end else if (!req_i) begin
                m_grant = 0; m_lock = 0;
            end else if (!m_grant && !m_lock && dbit_tick && s_now) begin
                m_grant = 1;
            end
            m_coll = was_coll;
            hist.push_back(sg_in);
            if (hist.size() > 8) void'(hist.pop_front());
        end
    end

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", tag, what, act, exp, cyc);
        end
    endtask

    always @(negedge clk) begin
        #1;
        if (rst_n && !done) begin
            bit e_sg, e_d;
            logic [5:0] e_ci;
            e_sg = access_dis_i | hist[$-1];
            e_ci = ci_ch2_i;
            if (ci_mirror_en_i && mode_i inside {3'd0, 3'd1, 3'd2, 3'd4}) e_ci[4] = e_sg;
            e_d = (access_dis_i || m_grant) ? d_tx_i : 1'b1;
            check(cur_tag, "grant", grant_o, m_grant);
            check("R5", "collision", collision_o, m_coll);
            check("R2", "sg_o", sg_o, e_sg);
            check((mode_i == 3'd7) ? "R9" : "R8", "ci_ch2", ci_ch2_o, e_ci);
            check((mode_i inside {3'd3, 3'd5, 3'd6}) ? "R11" : "R7", "d_line", d_line_o, e_d);
        end
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cyc++;
            dbit_tick = (cyc % 4 == 0);
            d_tx_i    = cyc[0] ^ cyc[2];
            ci_ch2_i  = 6'(cyc * 5);
        end
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        step(4);
        // R1: reset values while held
        check("R1", "grant in reset", grant_o, 0);
        check("R1", "collision in reset", collision_o, 0);
        check("R1", "sg_o in reset", sg_o, 0);
        check("R1", "d_line in reset", d_line_o, 1);
        rst_n = 1'b1;
        sg_in = 1'b1;
        step(6);
        cur_tag = "R3"; req_i = 1'b1; step(10);
        cur_tag = "R4"; step(5); req_i = 1'b0; step(3); req_i = 1'b1; step(8);
        // R5 collision then R6 lockout while request stays high
        cur_tag = "R5"; sg_in = 1'b0; step(4);
        cur_tag = "R6"; sg_in = 1'b1; step(12);
        req_i = 1'b0; step(2); req_i = 1'b1; step(8);
        // R5 collision coinciding with a request drop
        cur_tag = "R5"; sg_in = 1'b0; step(2); req_i = 1'b0; step(4);
        cur_tag = "R3"; req_i = 1'b1; step(12);
        sg_in = 1'b1; step(8);
        cur_tag = "R9"; mode_i = 3'd7; sg_in = 1'b0; step(4); sg_in = 1'b1; step(10);
        cur_tag = "R8"; mode_i = 3'd1; step(6); ci_mirror_en_i = 1'b0; step(6); ci_mirror_en_i = 1'b1;
        cur_tag = "R11"; mode_i = 3'd5; step(8); mode_i = 3'd3; step(6); mode_i = 3'd6; step(6);
        cur_tag = "R10"; mode_i = 3'd4; access_dis_i = 1'b1; sg_in = 1'b0; step(6);
        req_i = 1'b0; step(3); req_i = 1'b1; sg_in = 1'b1; step(3); sg_in = 1'b0; step(6);
        access_dis_i = 1'b0; cur_tag = "R3"; step(10);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule